// File: doc/BRIEF.md
# Snoop Control Register File

This block is the software-visible register set of a multi-core cluster's snoop control unit. It decodes a 256-byte offset window on a simple register bus. The bus carries an offset, write data, a write enable and a size field that gives the access width in bytes.

The block holds three things:
- a one-bit enable control;
- a read-only configuration word built from the core-count parameter;
- a 32-bit power status word, one byte per core.

The power status word can be read or written through four byte-offset windows. A write changes only the bytes that its size and offset select. Every other offset in the window reads as zero and drops writes.

Read data is registered. The value for the offset presented in one cycle appears on the read data port in the next cycle. Writes take effect at the clock edge where the write enable is sampled high.

Top module: `snoop_ctl_regs`

## Requirements
- R1: A write of a legal size to offset 0x00 stores bit 0 of the write data as the enable control. A read of 0x00 returns that bit in bit 0, with zeros above it.
- R2: A read of offset 0x04 returns (((1 << N) - 1) << 4) | (N - 1), where N is the core count. The default N=4 gives 0x000000F3. Writes to 0x04 change nothing.
- R3: Reads of offsets 0x08, 0x09, 0x0A and 0x0B return the power status word shifted right by 0, 8, 16 and 24 bits.
- R4: A write to offsets 0x08 to 0x0B with size 1, 2 or 4 builds a mask of 0xFF, 0xFFFF or 0xFFFFFFFF. The mask is shifted left by (offset - 8) * 8 and truncated to 32 bits. Only the bits under the shifted mask are replaced, with the write data shifted the same way.
- R5: The size field is 3 bits and holds the access width in bytes. A write whose size is anything other than 1, 2 or 4 is discarded at every offset, so neither the enable control nor the power status word changes.
- R6: Offset 0x0C reads as 0, and writes to it change nothing.
- R7: Offsets 0x40 and 0x44 read as 0 and ignore writes.
- R8: Offsets 0x50 and 0x54, and every other offset not listed in R1 to R7, read as 0 and ignore writes.
- R9: Read data for the offset presented in one cycle appears on the read data port after the next rising clock edge. Until that edge the port keeps the earlier value.
- R10: After reset, the enable control, the power status word and the read data port are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 8 | Byte offset within the register window |
| regWdata | input | 32 | Write data |
| regWe | input | 1 | Write enable |
| regSize | input | 3 | Access width in bytes (1, 2 or 4 are legal) |
| rdData | output | 32 | Registered read data |

## Verification
The assertions watch every cycle. They check that a write of an illegal size never raises either write strobe, and that at most one register is written in a cycle. They also check that the power status word holds when it is not written and never changes outside the active byte mask. Finally, they check that the read port returns zero, the configuration constant, the control bit or the unshifted status word according to the offset presented one cycle earlier.

The exact merge results for each size and offset pair, and the shifted reads of the upper windows, are shown only by the bench's scenarios. So are the fact that writes to the read-only and reserved offsets leave the control and status state untouched, and the one-cycle read latency seen at the ports.

// File: rtl/scu_reg_pkg.sv
package scu_reg_pkg;
  localparam int unsigned WordW  = 32;
  localparam int unsigned SizeW  = 3;
  localparam int unsigned ShiftW = $clog2(WordW);

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_CTRL = 2'd1,
    RD_CFG  = 2'd2,
    RD_PWR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic              ctrlWe;
    logic              pwrWe;
    logic [WordW-1:0]  pwrMask;
    logic [ShiftW-1:0] laneShift;
    rdSel_e            rdSel;
    logic [ShiftW-1:0] rdShift;
  } scuStrobe_t;
endpackage

// File: rtl/scu_reg_ctrl.sv
module scu_reg_ctrl
  import scu_reg_pkg::*;
#(
  parameter int unsigned AddrW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [AddrW-1:0]    regAddr,
  input  logic                regWe,
  input  logic [SizeW-1:0]    regSize,
  output scuStrobe_t          strb
);
  localparam logic [AddrW-1:0] OffCtrl = AddrW'(8'h00);
  localparam logic [AddrW-1:0] OffCfg  = AddrW'(8'h04);
  localparam logic [AddrW-1:0] OffPwr  = AddrW'(8'h08);

  logic             sizeOk;
  logic [WordW-1:0] sizeMask;
  logic [1:0]       lane;
  logic             inPwr;
  logic             isCtrl;

  always_comb begin
    sizeOk   = 1'b0;
    sizeMask = '0;
    case (regSize)
      SizeW'(1): begin sizeOk = 1'b1; sizeMask = WordW'(32'h0000_00FF); end
      SizeW'(2): begin sizeOk = 1'b1; sizeMask = WordW'(32'h0000_FFFF); end
      SizeW'(4): begin sizeOk = 1'b1; sizeMask = {WordW{1'b1}}; end
      default:   begin sizeOk = 1'b0; sizeMask = '0; end
    endcase
  end

  assign lane   = regAddr[1:0];
  assign inPwr  = (regAddr[AddrW-1:2] == OffPwr[AddrW-1:2]);
  assign isCtrl = (regAddr == OffCtrl);

  always_comb begin
    strb.ctrlWe    = regWe & sizeOk & isCtrl;
    strb.pwrWe     = regWe & sizeOk & inPwr;
    strb.laneShift = ShiftW'({lane, 3'b000});
    strb.pwrMask   = sizeMask << strb.laneShift;
    strb.rdShift   = ShiftW'({lane, 3'b000});
    if (inPwr)                strb.rdSel = RD_PWR;
    else if (isCtrl)          strb.rdSel = RD_CTRL;
    else if (regAddr == OffCfg) strb.rdSel = RD_CFG;
    else                      strb.rdSel = RD_ZERO;
  end

  AST_BAD_SIZE_DROP: assert property (@(posedge clk) disable iff (!rstN) // R5
    (regWe && !(regSize == SizeW'(1) || regSize == SizeW'(2) || regSize == SizeW'(4)))
      |-> !(strb.ctrlWe || strb.pwrWe));

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rstN) // R8
    $onehot0({strb.ctrlWe, strb.pwrWe}));
endmodule

// File: rtl/scu_reg_datapath.sv
module scu_reg_datapath
  import scu_reg_pkg::*;
#(
  parameter int unsigned NumCores = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WordW-1:0] regWdata,
  input  scuStrobe_t       strb,
  output logic [WordW-1:0] rdData
);
  localparam logic [WordW-1:0] CoreMask = WordW'((1 << NumCores) - 1);
  localparam logic [WordW-1:0] CfgWord  = (CoreMask << 4) | WordW'(NumCores - 1);

  logic             ctrlQ;
  logic [WordW-1:0] pwrQ;
  logic [WordW-1:0] rdQ;
  logic [WordW-1:0] rdNext;
  logic [WordW-1:0] pwrNext;

  assign pwrNext = (pwrQ & ~strb.pwrMask) | ((regWdata << strb.laneShift) & strb.pwrMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= 1'b0;
      pwrQ  <= '0;
    end else begin
      if (strb.ctrlWe) ctrlQ <= regWdata[0];
      if (strb.pwrWe)  pwrQ  <= pwrNext;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_CTRL: rdNext = {{(WordW-1){1'b0}}, ctrlQ};
      RD_CFG:  rdNext = CfgWord;
      RD_PWR:  rdNext = pwrQ >> strb.rdShift;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else       rdQ <= rdNext;
  end

  assign rdData = rdQ;

  AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rstN) // R5
    !strb.pwrWe |=> $stable(pwrQ));

  AST_PWR_MASKED: assert property (@(posedge clk) disable iff (!rstN) // R4
    strb.pwrWe |=> (((pwrQ ^ $past(pwrQ)) & ~$past(strb.pwrMask)) == '0));

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rstN) // R8
    (strb.rdSel == RD_ZERO) |=> (rdData == '0));

  AST_CFG_READ: assert property (@(posedge clk) disable iff (!rstN) // R2
    (strb.rdSel == RD_CFG) |=> (rdData == CfgWord));

  AST_CTRL_READ: assert property (@(posedge clk) disable iff (!rstN) // R1
    (strb.rdSel == RD_CTRL) |=> (rdData[WordW-1:1] == '0));

  AST_PWR_READ: assert property (@(posedge clk) disable iff (!rstN) // R3
    (strb.rdSel == RD_PWR && strb.rdShift == '0) |=> (rdData == $past(pwrQ)));
endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
  import scu_reg_pkg::*;
#(
  parameter int unsigned NumCores = 4,
  parameter int unsigned AddrW    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AddrW-1:0] regAddr,
  input  logic [31:0]      regWdata,
  input  logic             regWe,
  input  logic [2:0]       regSize,
  output logic [31:0]      rdData
);
  scuStrobe_t strb;

  scu_reg_ctrl #(.AddrW(AddrW)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .regSize (regSize),
    .strb    (strb)
  );

  scu_reg_datapath #(.NumCores(NumCores)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWdata (regWdata),
    .strb     (strb),
    .rdData   (rdData)
  );
endmodule

// File: tb/snoop_ctl_regs_tb.sv
module snoop_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = 32'h0;
  logic        regWe = 1'b0;
  logic [2:0]  regSize = 3'd4;
  logic [31:0] rdData;

  int checks = 0;
  int fails = 0;
  logic [31:0] pwrModel = 32'h0;
  logic        ctrlModel = 1'b0;

  always #4 clk = ~clk;

  snoop_ctl_regs dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regSize(regSize), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d, input logic [2:0] s);
    @(negedge clk);
    regAddr = a; regWdata = d; regSize = s; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regSize = 3'd4;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWe = 1'b0;
    @(negedge clk);
    d = rdData;
  endtask

  function automatic logic [31:0] mergePwr(input logic [31:0] old, input logic [7:0] a,
                                           input logic [31:0] d, input logic [2:0] s);
    logic [31:0] m;
    int sh;
    m = (s == 3'd1) ? 32'hFF : (s == 3'd2) ? 32'hFFFF : 32'hFFFF_FFFF;
    sh = (int'(a) - 8) * 8;
    return (old & ~(m << sh)) | ((d & m) << sh);
  endfunction

  task automatic testReset();
    logic [31:0] v;
    check("R10 rdData after reset", rdData, 32'h0);
    readReg(8'h00, v); check("R10 ctrl reset", v, 32'h0);
    readReg(8'h08, v); check("R10 pwr reset", v, 32'h0);
  endtask

  task automatic testCtrl();
    logic [31:0] v;
    writeReg(8'h00, 32'hFFFF_FFFF, 3'd4); ctrlModel = 1'b1;
    readReg(8'h00, v); check("R1 ctrl keeps bit0 only", v, 32'h1);
    writeReg(8'h00, 32'hFFFF_FFFE, 3'd1); ctrlModel = 1'b0;
    readReg(8'h00, v); check("R1 ctrl cleared", v, 32'h0);
    writeReg(8'h00, 32'h0000_0003, 3'd2); ctrlModel = 1'b1;
    readReg(8'h00, v); check("R1 ctrl halfword write", v, 32'h1);
  endtask

  task automatic testCfg();
    logic [31:0] v;
    readReg(8'h04, v); check("R2 cfg value", v, 32'h0000_00F3);
    writeReg(8'h04, 32'h0, 3'd4);
    readReg(8'h04, v); check("R2 cfg write ignored", v, 32'h0000_00F3);
  endtask

  task automatic pwrWrite(input logic [7:0] a, input logic [31:0] d, input logic [2:0] s);
    writeReg(a, d, s);
    pwrModel = mergePwr(pwrModel, a, d, s);
  endtask

  task automatic pwrReadAll(input string tag);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      readReg(8'h08 + 8'(k), v);
      check({"R3 ", tag}, v, pwrModel >> (8 * k));
    end
  endtask

  task automatic testPwrWord();
    logic [31:0] v;
    pwrWrite(8'h08, 32'hA5A5_1234, 3'd4);
    readReg(8'h08, v); check("R4 word write", v, 32'hA5A5_1234);
    pwrReadAll("windows after word write");
  endtask

  task automatic testPwrByteHalf();
    logic [31:0] v;
    pwrWrite(8'h09, 32'hFFFF_FF5C, 3'd1);
    readReg(8'h08, v); check("R4 byte at 0x09", v, 32'hA5A5_5C34);
    pwrWrite(8'h0A, 32'hFFFF_BEEF, 3'd2);
    readReg(8'h08, v); check("R4 half at 0x0A", v, 32'hBEEF_5C34);
    pwrWrite(8'h0B, 32'h1234_5677, 3'd2);
    readReg(8'h08, v); check("R4 half at 0x0B truncated", v, 32'h77EF_5C34);
    pwrWrite(8'h0B, 32'hCAFE_F00D, 3'd4);
    readReg(8'h08, v); check("R4 word at 0x0B truncated", v, 32'h0DEF_5C34);
    pwrWrite(8'h08, 32'h0000_0099, 3'd1);
    readReg(8'h08, v); check("R4 byte at 0x08", v, pwrModel);
    pwrReadAll("windows after merges");
  endtask

  task automatic testBadSize();
    logic [31:0] v;
    writeReg(8'h08, 32'h1111_1111, 3'd3);
    writeReg(8'h09, 32'h2222_2222, 3'd0);
    writeReg(8'h0A, 32'h3333_3333, 3'd5);
    writeReg(8'h08, 32'h4444_4444, 3'd7);
    readReg(8'h08, v); check("R5 bad size pwr unchanged", v, pwrModel);
    writeReg(8'h00, 32'h0, 3'd6);
    readReg(8'h00, v); check("R5 bad size ctrl unchanged", v, {31'h0, ctrlModel});
  endtask

  task automatic testZeroRegs();
    logic [31:0] v;
    logic [7:0] offs [8] = '{8'h0C, 8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'h10, 8'hFC};
    for (int k = 0; k < 8; k++) begin
      writeReg(offs[k], 32'hFFFF_FFFF, 3'd4);
      readReg(offs[k], v);
      if (k == 0) check("R6 invalidate reads zero", v, 32'h0);
      else if (k < 3) check("R7 filter reg reads zero", v, 32'h0);
      else check("R8 other offset reads zero", v, 32'h0);
    end
    readReg(8'h08, v); check("R8 pwr untouched by ignored writes", v, pwrModel);
    readReg(8'h00, v); check("R6 ctrl untouched by ignored writes", v, {31'h0, ctrlModel});
  endtask

  task automatic testLatency();
    logic [31:0] v;
    readReg(8'h40, v); check("R9 prior read zero", v, 32'h0);
    @(negedge clk);
    regAddr = 8'h08;
    #1;
    check("R9 no change before edge", rdData, 32'h0);
    @(negedge clk);
    check("R9 value after one edge", rdData, pwrModel);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtrl();
    testCfg();
    testPwrWord();
    testPwrByteHalf();
    testBadSize();
    testZeroRegs();
    testLatency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule